// File: doc/BRIEF.md
# Full-Bridge Drive Sequencer with Cycle-by-Cycle Current Trip

This block produces the four switch enables of a full bridge that runs as a fixed-ratio DC transformer. Each switching period is made of two equal halves. In the first half the A diagonal conducts (left high switch and right low switch). In the second half the B diagonal conducts (right high switch and left low switch). Each half has a fixed conduction stretch followed by a short dead interval in which every switch is off. Nothing regulates the duty. At the default of 500 clock cycles per half and a 50 MHz clock the bridge switches at 50 kHz. A dead interval of 25 cycles per half gives 95 % conduction.

An active-low over-current comparator input ends the conducting half early when it falls. A falling edge is accepted only after a programmable leading-edge blanking count, which masks the noise at each switching edge. An accepted trip ends only the current half, and the opposite diagonal starts on time. A sample gate is high exactly while a diagonal conducts, so that an external averaging sample-and-hold sees the sense signal only then. A saturating count of accepted trips lets a supervisor escalate repeated faults.

The controller is a five-state machine. The states are IDLE, DRIVE_A, DEAD_A, DRIVE_B and DEAD_B. The transitions are:
- IDLE→DRIVE_A when enabled.
- DRIVE_A→DEAD_A when the conduction count is reached or a trip is accepted.
- DEAD_A→DRIVE_B at the end of the half.
- DRIVE_B→DEAD_B on the same conditions as DRIVE_A→DEAD_A.
- DEAD_B→DRIVE_A at the end of the half.
- Any state→IDLE when enable is low.

Top module: `fb_pwm_ilim`

## Requirements
- R1: After reset, and from the first clock after `en` is sampled low, all four switch enables and `sh_gate` are low. After reset `trip_count` is 0.
- R2: When `en` is sampled high in IDLE, the A diagonal (`drv_a_hi`=1, `drv_b_lo`=1) is on from the next cycle. After that, half periods of HALF_CYC cycles alternate A, B, A and so on. The B diagonal is `drv_b_hi`=1 and `drv_a_lo`=1.
- R3: In each half the diagonal conducts for HALF_CYC minus D cycles, then all switches are off for D cycles. D is `dead_cyc`. A value of 0 is treated as 1, and a value of HALF_CYC or more is treated as HALF_CYC-1.
- R4: The high and low switches of one leg are never on together.
- R5: A high-to-low transition of `oc_n`, sampled while a diagonal conducts and with the in-half cycle index (0 at the first conducting cycle) at or above `blank_cyc`, turns the diagonal off from the next cycle for the rest of that half. The next half starts on schedule.
- R6: A falling edge of `oc_n` sampled at an in-half index below `blank_cyc` has no effect on the outputs or on `trip_count`.
- R7: Only a falling edge trips. A level of `oc_n` held low, or a fall during a dead interval or in IDLE, has no effect.
- R8: `sh_gate` is high exactly in the cycles in which a diagonal conducts.
- R9: Each accepted trip raises `trip_count` by one on the same clock edge that ends the drive. The count saturates at its all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low forces IDLE |
| oc_n | input | 1 | Over-current comparator, low when the limit is exceeded |
| blank_cyc | input | CW | Leading-edge blanking length in clock cycles |
| dead_cyc | input | CW | Dead interval per half in clock cycles |
| drv_a_hi | output | 1 | Left leg high-switch enable |
| drv_a_lo | output | 1 | Left leg low-switch enable |
| drv_b_hi | output | 1 | Right leg high-switch enable |
| drv_b_lo | output | 1 | Right leg low-switch enable |
| sh_gate | output | 1 | Sample gate, high while a diagonal conducts |
| trip_count | output | TRIP_W | Saturating count of accepted trips |

## Verification
A comparator fall can arrive in the same cycle as the natural end of conduction, the last cycle before the dead interval. Both paths then move the machine to its dead state. The bench drops `oc_n` so that it is sampled at in-half index HALF_CYC-1-D. It then checks that the outputs go low at exactly the usual cycle, that `trip_count` still advances, and that the next half starts on time. The blanking boundary is a second meeting point, where the blanking count and the trip compare coincide. A fall sampled one index before `blank_cyc` must be ignored, and a fall sampled at `blank_cyc` itself must be accepted.

// File: rtl/fbp_pkg.sv
`timescale 1ns/1ps
package fbp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_DRV_A  = 3'd1,
        ST_DEAD_A = 3'd2,
        ST_DRV_B  = 3'd3,
        ST_DEAD_B = 3'd4
    } fb_state_t;
endpackage

// File: rtl/fbp_half_timer.sv
`timescale 1ns/1ps
// Position counter inside one half period; wraps by itself at the end.
module fbp_half_timer #(
    parameter int HALF_CYC = 500,
    localparam int CW = $clog2(HALF_CYC)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    output logic [CW-1:0] cnt,
    output logic          at_end
);
    localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

    assign at_end = (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               cnt <= '0;
        else if (clr || at_end)   cnt <= '0;
        else                      cnt <= cnt + 1'b1;
    end

    // R2: a half never exceeds HALF_CYC cycles
    p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
endmodule

// File: rtl/fbp_fall_det.sv
`timescale 1ns/1ps
// Falling-edge detector for the active-low comparator level.
module fbp_fall_det (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_n,
    output logic fell
);
    logic prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= 1'b1;
        else        prev <= lvl_n;
    end

    assign fell = prev && !lvl_n;

    // R7: a steady low level yields no further edges
    p_single_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fell |=> !fell);
endmodule

// File: rtl/fbp_trip_ctr.sv
`timescale 1ns/1ps
// Saturating counter of accepted trips.
module fbp_trip_ctr #(
    parameter int TRIP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc,
    output logic [TRIP_W-1:0] count
);
    localparam logic [TRIP_W-1:0] TOP = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    count <= '0;
        else if (inc && count != TOP)  count <= count + 1'b1;
    end

    p_trip_inc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && count != TOP) |=> count == $past(count) + 1'b1);
    p_trip_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (count == TOP) |=> count == TOP);
    p_trip_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(count));
endmodule

// File: rtl/fb_pwm_ilim.sv
`timescale 1ns/1ps
module fb_pwm_ilim
    import fbp_pkg::*;
#(
    parameter int HALF_CYC = 500,
    parameter int TRIP_W   = 8,
    localparam int CW      = $clog2(HALF_CYC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              oc_n,
    input  logic [CW-1:0]     blank_cyc,
    input  logic [CW-1:0]     dead_cyc,
    output logic              drv_a_hi,
    output logic              drv_a_lo,
    output logic              drv_b_hi,
    output logic              drv_b_lo,
    output logic              sh_gate,
    output logic [TRIP_W-1:0] trip_count
);
    localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

    fb_state_t     state, state_nx;
    logic [CW-1:0] cnt;
    logic          at_end;
    logic          oc_fell;
    logic          driving;
    logic          trip;
    logic [CW-1:0] dead_eff;
    logic [CW-1:0] on_last;

    // dead interval clamped to 1 .. HALF_CYC-1
    always_comb begin
        if (dead_cyc == '0)        dead_eff = CW'(1);
        else if (dead_cyc > LAST)  dead_eff = LAST;
        else                       dead_eff = dead_cyc;
    end
    assign on_last = LAST - dead_eff;

    fbp_half_timer #(.HALF_CYC(HALF_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (state == ST_IDLE),
        .cnt    (cnt),
        .at_end (at_end)
    );

    fbp_fall_det u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_n (oc_n),
        .fell  (oc_fell)
    );

    assign driving = (state == ST_DRV_A) || (state == ST_DRV_B);
    assign trip    = en && driving && oc_fell && (cnt >= blank_cyc);

    fbp_trip_ctr #(.TRIP_W(TRIP_W)) u_trips (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (trip),
        .count (trip_count)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (en) state_nx = ST_DRV_A;
            ST_DRV_A: begin
                if (!en)                            state_nx = ST_IDLE;
                else if (trip || cnt == on_last)    state_nx = ST_DEAD_A;
            end
            ST_DEAD_A: begin
                if (!en)          state_nx = ST_IDLE;
                else if (at_end)  state_nx = ST_DRV_B;
            end
            ST_DRV_B: begin
                if (!en)                            state_nx = ST_IDLE;
                else if (trip || cnt == on_last)    state_nx = ST_DEAD_B;
            end
            ST_DEAD_B: begin
                if (!en)          state_nx = ST_IDLE;
                else if (at_end)  state_nx = ST_DRV_A;
            end
            default:              state_nx = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        drv_a_hi = 1'b0;
        drv_a_lo = 1'b0;
        drv_b_hi = 1'b0;
        drv_b_lo = 1'b0;
        unique case (state)
            ST_DRV_A: begin drv_a_hi = 1'b1; drv_b_lo = 1'b1; end
            ST_DRV_B: begin drv_b_hi = 1'b1; drv_a_lo = 1'b1; end
            default: ;
        endcase
        sh_gate = driving;
    end

    p_leg_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(drv_a_hi && drv_a_lo) && !(drv_b_hi && drv_b_lo));
    p_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !(drv_a_hi || drv_a_lo || drv_b_hi || drv_b_lo || sh_gate));
    p_alt_ab_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEAD_A && en && at_end) |=> drv_b_hi && drv_a_lo);
    p_alt_ba_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEAD_B && en && at_end) |=> drv_a_hi && drv_b_lo);
    p_trip_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        trip |=> !sh_gate);
    p_blank_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRV_A && en && cnt < blank_cyc && cnt != on_last)
        |=> drv_a_hi);
    p_gate_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sh_gate) |-> (drv_a_hi ^ drv_b_hi));
endmodule

// File: tb/fb_pwm_ilim_test.sv
`timescale 1ns/1ps
module fb_pwm_ilim_test;
    localparam int HALF = 500;
    localparam int CW   = $clog2(HALF);
    localparam int TW   = 3;
    localparam logic [7:0] G_A   = 8'b0001_0011;
    localparam logic [7:0] G_B   = 8'b0000_1101;
    localparam logic [7:0] G_OFF = 8'b0000_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic oc_n = 1'b1;
    logic [CW-1:0] blank_cyc = '0;
    logic [CW-1:0] dead_cyc = '0;
    logic drv_a_hi, drv_a_lo, drv_b_hi, drv_b_lo, sh_gate;
    logic [TW-1:0] trip_count;

    int checks = 0;
    int fails  = 0;
    int t      = 0;
    int exp_trips = 0;

    always #10 clk = ~clk;

    fb_pwm_ilim #(.HALF_CYC(HALF), .TRIP_W(TW)) uut (
        .clk(clk), .rst_n(rst_n), .en(en), .oc_n(oc_n),
        .blank_cyc(blank_cyc), .dead_cyc(dead_cyc),
        .drv_a_hi(drv_a_hi), .drv_a_lo(drv_a_lo),
        .drv_b_hi(drv_b_hi), .drv_b_lo(drv_b_lo),
        .sh_gate(sh_gate), .trip_count(trip_count)
    );

    function automatic logic [7:0] gates();
        return {3'b000, drv_a_hi, drv_a_lo, drv_b_hi, drv_b_lo, sh_gate};
    endfunction

    task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s at t=%0d: actual %0h expected %0h", req, what, t, act, exp);
        end
    endtask

    task automatic chk_trips(string req);
        chk(req, "trip_count", 8'(trip_count), 8'(exp_trips));
    endtask

    task automatic bump_trip();
        if (exp_trips < (1 << TW) - 1) exp_trips++;
    endtask

    task automatic step_to(int n);
        while (t < n) begin
            @(negedge clk);
            t++;
        end
    endtask

    task automatic start_run(int dead, int blank);
        @(negedge clk);
        dead_cyc  = CW'(dead);
        blank_cyc = CW'(blank);
        en = 1'b0;
        repeat (2) @(negedge clk);
        en = 1'b1;
        t = 0;
    endtask

    task automatic stop_run();
        @(negedge clk);
        en = 1'b0;
        oc_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        #5;
        chk("R1", "gates in reset", gates(), G_OFF);
        chk_trips("R1");
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", "gates idle", gates(), G_OFF);
    endtask

    task automatic t_normal();
        start_run(25, 15);
        step_to(1);   chk("R2", "A starts", gates(), G_A);
        step_to(475); chk("R3", "A last on", gates(), G_A);
        step_to(476); chk("R3", "A dead", gates(), G_OFF);
        step_to(500); chk("R8", "dead end", gates(), G_OFF);
        step_to(501); chk("R2", "B starts", gates(), G_B);
        step_to(975); chk("R3", "B last on", gates(), G_B);
        step_to(976); chk("R3", "B dead", gates(), G_OFF);
        step_to(1001); chk("R2", "A again", gates(), G_A);
        stop_run();
    endtask

    task automatic t_dead_zero();
        start_run(0, 15);
        step_to(499); chk("R3", "dead0 last on", gates(), G_A);
        step_to(500); chk("R3", "dead0 one off", gates(), G_OFF);
        step_to(501); chk("R3", "dead0 B", gates(), G_B);
        stop_run();
    endtask

    task automatic t_trip();
        start_run(25, 15);
        step_to(100); oc_n = 1'b0;
        step_to(101); bump_trip();
        chk("R5", "A cut", gates(), G_OFF);
        chk_trips("R9");
        step_to(300); chk("R5", "stays off", gates(), G_OFF);
        step_to(501); chk("R5", "B resumes", gates(), G_B);
        step_to(520); oc_n = 1'b1;
        step_to(975); chk("R5", "B full", gates(), G_B);
        stop_run();
    endtask

    task automatic t_blank();
        start_run(25, 15);
        step_to(15); oc_n = 1'b0;
        step_to(16); chk("R6", "blanked fall", gates(), G_A);
        chk_trips("R6");
        step_to(30); chk("R6", "still on", gates(), G_A);
        oc_n = 1'b1;
        step_to(516); oc_n = 1'b0;
        step_to(517); bump_trip();
        chk("R5", "edge at blank cut B", gates(), G_OFF);
        chk_trips("R9");
        stop_run();
    endtask

    task automatic t_level();
        @(negedge clk); oc_n = 1'b0;
        start_run(25, 15);
        step_to(300); chk("R7", "low level A", gates(), G_A);
        step_to(478); oc_n = 1'b1;
        step_to(480); oc_n = 1'b0;
        step_to(700); chk("R7", "low level B", gates(), G_B);
        chk_trips("R7");
        stop_run();
    endtask

    task automatic t_coincide();
        start_run(25, 15);
        step_to(475); oc_n = 1'b0;
        step_to(476); bump_trip();
        chk("R5", "coincide off", gates(), G_OFF);
        chk_trips("R9");
        step_to(501); chk("R2", "coincide B", gates(), G_B);
        stop_run();
    endtask

    task automatic t_enable_drop();
        start_run(25, 15);
        step_to(600); chk("R2", "B before drop", gates(), G_B);
        en = 1'b0;
        step_to(601); chk("R1", "en low off", gates(), G_OFF);
        step_to(610);
        en = 1'b1; t = 0;
        step_to(1); chk("R2", "restart on A", gates(), G_A);
        stop_run();
    endtask

    task automatic t_saturate();
        start_run(25, 15);
        for (int k = 0; k < 6; k++) begin
            step_to(50 + 500 * k); oc_n = 1'b0;
            step_to(51 + 500 * k); bump_trip();
            chk_trips("R9");
            step_to(60 + 500 * k); oc_n = 1'b1;
        end
        chk("R9", "saturated", 8'(trip_count), 8'((1 << TW) - 1));
        stop_run();
    endtask

    initial begin
        #3_000_000;
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_normal();
        t_dead_zero();
        t_trip();
        t_blank();
        t_level();
        t_coincide();
        t_enable_drop();
        t_saturate();
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule